// File: doc/BRIEF.md
# Trick-Play Mode and Interrupt Controller

This block sits between a host register port and a video decoding core. It holds the fast-scan mode and the still-picture and frame-advance mode. From these it drives four controls to the core: a one-cycle input-buffer flush, an audio mute, an I-frame-only restriction and a single-frame advance request. The core reports when a frame has been shown, and the block uses that to retire a pending frame advance. It never lets fast-scan and still modes be active at the same time.

The block also collects single-cycle event pulses from the core into an 8-bit interrupt status register. Some of these events are kept only in certain playback modes. The status register clears when the host reads it, and an event that arrives in the same cycle as that read is not lost. An enable mask selects which status bits drive the single interrupt request line.

The host uses a 2-bit address with separate write and read strobes and 8-bit data. Address 0 holds the fast mode in bit 0. Address 1 holds the still mode in bit 1 and frame advance in bit 0. Address 2 is the status register and is read-only. Address 3 is the enable mask.

Top module: `trickplay_irq_ctrl`

## Requirements
- R1: A pulse on evt_i[k] sets status bit k, and the bit stays set until it is cleared. The bit map is: 7 DMA request, 6 time-out, 5 I-frame decoded, 4 I-frame found, 3 user data found, 2 buffer full, 1 data error, 0 underflow. Bits 7, 6, 1 and 0 are recorded in every mode.
- R2: A read at address 2 returns the status as it was before the read and clears every bit. An event that arrives in the same cycle as that read is still recorded.
- R3: The enable mask at address 3 is written with wdata_i. irq_o is high exactly when some status bit and its enable bit are both 1.
- R4: Status bits 5, 4 and 3 are recorded only while fast mode, still mode or frame advance is active.
- R5: Status bit 2 is recorded only in streaming mode, meaning fast mode, still mode and frame advance are all inactive.
- R6: Writing 1 to bit 0 of address 0 sets fast mode. While fast mode is set, mute_o and iframe_only_o are high. A write that changes fast mode or still mode from 0 to 1 makes flush_o high for exactly the one cycle after the write.
- R7: At address 1, bit 1 drives still_o and bit 0 drives advance_o. advance_o clears in the cycle after shown_i is seen while it is set, unless that same cycle also has a write to address 1.
- R8: A write that would leave fast mode active together with a nonzero still register is rejected, and both mode registers keep their previous values.
- R9: After reset, the status, enable and both mode registers are 0, and so are irq_o, flush_o, mute_o, iframe_only_o, still_o and advance_o.
- R10: While rd_i is high, rdata_o shows the register at addr_i: {7'b0, fast} at address 0, {6'b0, still, advance} at address 1, the status at address 2 and the mask at address 3. While rd_i is low, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Host register address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| evt_i | input | 8 | Event pulses from the core, one per status bit |
| shown_i | input | 1 | Core has displayed an I-frame |
| irq_o | output | 1 | Interrupt request |
| flush_o | output | 1 | One-cycle flush of the input buffers |
| mute_o | output | 1 | Audio mute |
| iframe_only_o | output | 1 | Restrict decoding to I-frames |
| still_o | output | 1 | Still-picture mode |
| advance_o | output | 1 | Frame advance request |

## Verification
Some properties are checked by assertions on every cycle. Fast mode and still mode are never active together. The flush is a single cycle, and it accompanies every rise of mute. A frame advance retires after shown_i. A status read with no events leaves the status and the request line clear. The mode gating of bits 2 and 5:3 holds across a read. Other behaviour can only be shown by the bench scenarios: the exact status values after mixed event bursts in each mode, keeping an event that lands on a read, the masking of specific sources, the readback of each register and the rejection of conflicting mode writes.

// File: rtl/trick_pkg.sv
package trick_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FAST  = 2'd0,
    ADR_STILL = 2'd1,
    ADR_STAT  = 2'd2,
    ADR_EN    = 2'd3
  } reg_addr_e;

  // status bit positions
  localparam int unsigned B_UFLOW = 0;
  localparam int unsigned B_DERR  = 1;
  localparam int unsigned B_FULL  = 2;
  localparam int unsigned B_UDATA = 3;
  localparam int unsigned B_IFND  = 4;
  localparam int unsigned B_IDEC  = 5;
  localparam int unsigned B_TOUT  = 6;
  localparam int unsigned B_DMA   = 7;

  typedef enum logic [1:0] {
    QUAL_ALWAYS,
    QUAL_TRICK,
    QUAL_STREAM
  } qual_e;

  function automatic qual_e bit_qual(int unsigned idx);
    if (idx == B_IDEC || idx == B_IFND || idx == B_UDATA) return QUAL_TRICK;
    if (idx == B_FULL) return QUAL_STREAM;
    return QUAL_ALWAYS;
  endfunction
endpackage

// File: rtl/tp_mode_regs.sv
module tp_mode_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_fast_i,
  input  logic       wr_still_i,
  input  logic [1:0] wdata_i,
  input  logic       shown_i,
  output logic       fast_o,
  output logic [1:0] still_o,
  output logic       flush_o,
  output logic       trick_o
);
  logic       fast_q;
  logic [1:0] still_q;
  logic       flush_q;
  logic       fast_ok, still_ok;

  // reject writes that would overlap fast and still modes
  assign fast_ok  = wr_fast_i  && !(wdata_i[0] && (still_q != 2'b00));
  assign still_ok = wr_still_i && !((wdata_i != 2'b00) && fast_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q  <= 1'b0;
      still_q <= 2'b00;
      flush_q <= 1'b0;
    end else begin
      if (fast_ok) fast_q <= wdata_i[0];
      if (still_ok) still_q <= wdata_i;
      else if (still_q[0] && shown_i) still_q[0] <= 1'b0;
      flush_q <= (fast_ok && wdata_i[0] && !fast_q) ||
                 (still_ok && wdata_i[1] && !still_q[1]);
    end
  end

  assign fast_o  = fast_q;
  assign still_o = still_q;
  assign flush_o = flush_q;
  assign trick_o = fast_q || (still_q != 2'b00);
endmodule

// File: rtl/tp_irq_status.sv
module tp_irq_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         trick_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);
  import trick_pkg::*;

  logic [W-1:0] qual;
  logic [W-1:0] status_q;

  for (genvar g = 0; g < W; g++) begin : g_qual
    if (bit_qual(g) == QUAL_TRICK) begin : g_trick
      assign qual[g] = trick_i;
    end else if (bit_qual(g) == QUAL_STREAM) begin : g_stream
      assign qual[g] = !trick_i;
    end else begin : g_always
      assign qual[g] = 1'b1;
    end
  end

  // new events win over the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | (evt_i & qual);
  end

  assign status_o = status_q;
endmodule

// File: rtl/trickplay_irq_ctrl.sv
module trickplay_irq_ctrl
  import trick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              shown_i,
  output logic              irq_o,
  output logic              flush_o,
  output logic              mute_o,
  output logic              iframe_only_o,
  output logic              still_o,
  output logic              advance_o
);
  localparam int unsigned PAD_FAST  = DATA_W - 1;
  localparam int unsigned PAD_STILL = DATA_W - 2;

  logic              fast;
  logic [1:0]        still;
  logic              trick;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] enable;

  wire wr_fast  = wr_i && (addr_i == ADR_FAST);
  wire wr_still = wr_i && (addr_i == ADR_STILL);
  wire wr_en    = wr_i && (addr_i == ADR_EN);
  wire rd_stat  = rd_i && (addr_i == ADR_STAT);

  tp_mode_regs i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_fast_i (wr_fast),
    .wr_still_i(wr_still),
    .wdata_i   (wdata_i[1:0]),
    .shown_i   (shown_i),
    .fast_o    (fast),
    .still_o   (still),
    .flush_o   (flush_o),
    .trick_o   (trick)
  );

  tp_irq_status #(.W(DATA_W)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .trick_i (trick),
    .clr_i   (rd_stat),
    .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    enable <= '0;
    else if (wr_en) enable <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADR_FAST:  rdata_o = {{PAD_FAST{1'b0}}, fast};
        ADR_STILL: rdata_o = {{PAD_STILL{1'b0}}, still};
        ADR_STAT:  rdata_o = status;
        default:   rdata_o = enable;
      endcase
    end
  end

  assign irq_o         = |(status & enable);
  assign mute_o        = fast;
  assign iframe_only_o = fast;
  assign still_o       = still[1];
  assign advance_o     = still[0];
endmodule

// File: rtl/trickplay_irq_ctrl_chk.sv
module trickplay_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] evt_i,
  input logic       shown_i,
  input logic       irq_o,
  input logic       flush_o,
  input logic       mute_o,
  input logic       still_o,
  input logic       advance_o,
  input logic [7:0] status
);
  wire rd_stat = rd_i && (addr_i == 2'd2);

  AST_MODE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mute_o && (still_o || advance_o))); // R8
  AST_FLUSH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R6
  AST_FAST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> flush_o); // R6
  AST_ADV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_o && shown_i && !(wr_i && addr_i == 2'd1)) |=> !advance_o); // R7
  AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> status[0]); // R1
  AST_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == 8'h00) |=> (status == 8'h00)); // R2
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == 8'h00) |=> !irq_o); // R3
  AST_FULL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && rd_stat) |=> !status[2]); // R5
  AST_TRICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_o && !still_o && !advance_o && rd_stat) |=> (status[5:3] == 3'b000)); // R4
endmodule

bind trickplay_irq_ctrl trickplay_irq_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .evt_i    (evt_i),
  .shown_i  (shown_i),
  .irq_o    (irq_o),
  .flush_o  (flush_o),
  .mute_o   (mute_o),
  .still_o  (still_o),
  .advance_o(advance_o),
  .status   (status)
);

// File: tb/test_trickplay_irq_ctrl.sv
module test_trickplay_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, evt = '0;
  logic       shown = 1'b0;
  logic [7:0] rdata;
  logic       irq, flush, mute, ionly, still, adv;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  trickplay_irq_ctrl i_trickplay_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .shown_i(shown),
    .irq_o(irq), .flush_o(flush), .mute_o(mute), .iframe_only_o(ionly),
    .still_o(still), .advance_o(adv)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data with scoreboard, mid-cycle
  always @(negedge clk) begin
    if (rd) begin
      if (exp_q.size() == 0) check(rdata, 8'hxx, "scoreboard empty");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end else if (rdata !== 8'h00) begin
      check(rdata, 8'h00, "R10 idle data");
    end
  end

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic [7:0] exp, input string tag,
                         input logic [7:0] ev = 8'h00);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd = 1'b1; evt = ev;
    @(posedge clk); #1;
    rd = 1'b0; evt = 8'h00;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    @(posedge clk); #1;
    evt = ev;
    @(posedge clk); #1;
    evt = 8'h00;
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    check({2'b0, irq, flush, mute, ionly, still, adv}, 8'h00, "R9 outputs after reset");
    host_rd(2'd0, 8'h00, "R9 fast reset");
    host_rd(2'd1, 8'h00, "R9 still reset");
    host_rd(2'd2, 8'h00, "R9 status reset");
    host_rd(2'd3, 8'h00, "R9 enable reset");

    // streaming: trick bits dropped (R4), buffer full kept (R5)
    pulse_evt(8'hFF);
    host_rd(2'd2, 8'hC7, "R1 R4 R5 streaming status");
    host_rd(2'd2, 8'h00, "R2 cleared by read");

    // mask (R3)
    host_wr(2'd3, 8'h01);
    host_rd(2'd3, 8'h01, "R10 enable readback");
    pulse_evt(8'h02);
    check(irq, 1'b0, "R3 masked source");
    pulse_evt(8'h01);
    check(irq, 1'b1, "R3 enabled source");
    host_rd(2'd2, 8'h03, "R1 status two events");
    check(irq, 1'b0, "R3 irq after clear");

    // event in the read cycle survives (R2)
    host_rd(2'd2, 8'h00, "R2 read with event", 8'h80);
    host_rd(2'd2, 8'h80, "R2 event kept");

    // fast mode (R6)
    host_wr(2'd0, 8'h01);
    check({flush, mute, ionly}, 3'b111, "R6 fast set outputs");
    @(posedge clk); #1;
    check(flush, 1'b0, "R6 flush one cycle");
    check(mute, 1'b1, "R6 mute held");
    pulse_evt(8'hFF);
    host_rd(2'd2, 8'hFB, "R4 R5 fast status");
    host_rd(2'd0, 8'h01, "R10 fast readback");

    // conflicting still write rejected (R8)
    host_wr(2'd1, 8'h02);
    host_rd(2'd1, 8'h00, "R8 still write rejected");
    check(still, 1'b0, "R8 still_o stays low");
    host_wr(2'd0, 8'h00);
    check({mute, ionly}, 2'b00, "R6 fast cleared");

    // still + advance (R7)
    host_wr(2'd1, 8'h03);
    check({flush, still, adv}, 3'b111, "R6 R7 still set");
    host_wr(2'd0, 8'h01);
    host_rd(2'd0, 8'h00, "R8 fast write rejected");
    pulse_evt(8'h38);
    host_rd(2'd2, 8'h38, "R4 still mode trick events");
    @(posedge clk); #1;
    shown = 1'b1;
    @(posedge clk); #1;
    shown = 1'b0;
    check({still, adv}, 2'b10, "R7 advance self-clear");
    host_rd(2'd1, 8'h02, "R7 still readback");
    host_wr(2'd1, 8'h00);
    pulse_evt(8'h04);
    host_rd(2'd2, 8'h04, "R5 streaming again");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "scoreboard leftover");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule